// File: doc/BRIEF.md
# Four-Pin Configurable Digital I/O Controller

This block manages four general-purpose digital pins. Each pin holds its own six-bit setting word. A new word is accepted only when that pin's load strobe is pulsed. An output pin drives either a programmed level or an externally supplied feature clock onto the pad. An input pin reports one of two things in its status bit: its synchronized level, or a sticky alarm that latches on a chosen edge. The block also produces pad pull-up and pull-down enables for every pin.

Software writes a setting word on `cfg_wdata` together with a one-hot or multi-hot `cfg_load` mask. Every pin whose mask bit is set takes the word on that clock edge. The stored word of any pin can be read back through `rd_pin`/`rd_cfg`. All ports are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Setting word layout, LSB first:
- bit0 `out_en`: 1 = output.
- bit1 `val_alm`: output value, or for an input 1 = alarm reporting.
- bit2 `arm`.
- bit3 `edge_clk`: for an input 1 = rising edge and 0 = falling edge; for an output 1 = drive the feature clock.
- bit4 `pu`.
- bit5 `pd`.

Top module: `dio_quad`

## Requirements
- R1: After reset, pins 0 to 2 hold setting 6'b000000 (input, level reporting, no pulls). Pin 3 holds 6'b001001 (output driving `feat_clk`).
- R2: A pin's setting changes only on a clock edge where its `cfg_load` bit is 1. `cfg_wdata` with no load bit set has no effect, and a load for one pin leaves the other pins unchanged.
- R3: `pad_oe[i]` equals bit0 of pin i's setting one clock after the load.
- R4: An output pin drives bit1 of its setting on `pad_out[i]` when bit3 is 0, and drives `feat_clk` when bit3 is 1. An input pin drives `pad_out[i]` = 0.
- R5: When a pin is not in alarm mode (an output, or an input with bit1 = 0), `status[i]` equals `pad_in[i]` delayed by a two-flop synchronizer, two clocks.
- R6: An input with bit1 = 1 and bit2 = 1 latches `status[i]` = 1 within three clocks of a `pad_in[i]` edge of the selected kind (bit3 = 1 rising, 0 falling). Edges of the other kind, and all edges while bit2 = 0, do not set it.
- R7: A latched alarm stays set whatever the pad does, until the next load of that pin clears it.
- R8: `pull_up[i]` equals bit4. `pull_dn[i]` is 1 only when bit5 = 1 and bit4 = 0.
- R9: `status` bit i belongs to pin i for i = 0 to 3.
- R10: `rd_cfg` returns the stored setting word of the pin selected by `rd_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wdata | input | 6 | Setting word to load |
| cfg_load | input | 4 | Per-pin load strobe |
| rd_pin | input | 2 | Pin whose setting is read back |
| rd_cfg | output | 6 | Stored setting of the selected pin |
| feat_clk | input | 1 | Feature clock for output pins |
| pad_in | input | 4 | Pad input levels (asynchronous) |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |
| pull_up | output | 4 | Pull-up enables |
| pull_dn | output | 4 | Pull-down enables |
| status | output | 4 | Level or alarm per pin |

## Verification
The assertions check several rules on every cycle:
- the pull priority;
- that settings hold between loads;
- that a load clears the alarm on the next cycle;
- that an alarm only rises while the pin is an armed, alarm-reporting input;
- the fixed two-clock synchronizer delay.

Other behaviours appear only in the bench scenarios:
- the selected edge, and not the opposite edge, sets the alarm;
- an unarmed pin ignores edges;
- the feature clock reaches the pad;
- the reset defaults are in place;
- loads stay isolated between pins.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic pd;
    logic pu;
    logic edge_clk;
    logic arm;
    logic val_alm;
    logic out_en;
  } dio_cfg_t;

  localparam int unsigned CFG_W = $bits(dio_cfg_t);
  localparam dio_cfg_t CFG_IDLE   = '0;
  localparam dio_cfg_t CFG_CLKOUT = '{pd: 1'b0, pu: 1'b0, edge_clk: 1'b1,
                                      arm: 1'b0, val_alm: 1'b0, out_en: 1'b1};
endpackage

// File: rtl/dio_sync.sv
module dio_sync
  import dio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [SYNC_DEPTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[SYNC_DEPTH-2:0], d};
  end

  assign q = stage_q[SYNC_DEPTH-1];

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R5: the synchronized level trails the pad by exactly two clocks
  a_r5_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (q == $past(d, 2)));
endmodule

// File: rtl/dio_pin.sv
module dio_pin
  import dio_pkg::*;
#(
  parameter dio_cfg_t RST_CFG = CFG_IDLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_in,
  input  logic             feat_clk,
  input  logic             load,
  input  logic [CFG_W-1:0] wdata,
  output dio_cfg_t         cfg_o,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pull_up,
  output logic             pull_dn,
  output logic             status
);
  dio_cfg_t cfg_q;
  logic     lvl, prev_q, alarm_q, hit, alarm_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= RST_CFG;
    else if (load) cfg_q <= dio_cfg_t'(wdata);
  end

  dio_sync u_sync (.clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl));

  assign hit        = cfg_q.edge_clk ? (lvl & ~prev_q) : (~lvl & prev_q);
  assign alarm_mode = ~cfg_q.out_en & cfg_q.val_alm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (load)                                 alarm_q <= 1'b0;
      else if (alarm_mode && cfg_q.arm && hit)  alarm_q <= 1'b1;
    end
  end

  always_comb begin
    pad_oe  = cfg_q.out_en;
    pad_out = cfg_q.out_en & (cfg_q.edge_clk ? feat_clk : cfg_q.val_alm);
    pull_up = cfg_q.pu;
    pull_dn = cfg_q.pd & ~cfg_q.pu;
    status  = alarm_mode ? alarm_q : lvl;
  end

  assign cfg_o = cfg_q;

  a_r8_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pull_up && pull_dn));
  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
  a_r7_load_clears_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !alarm_q);
  a_r6_alarm_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> (!cfg_q.out_en && cfg_q.val_alm && cfg_q.arm));
endmodule

// File: rtl/dio_quad.sv
module dio_quad
  import dio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned CLK_PIN  = 3,
  localparam int unsigned SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic [NUM_PINS-1:0] cfg_load,
  input  logic [SEL_W-1:0]    rd_pin,
  output logic [CFG_W-1:0]    rd_cfg,
  input  logic                feat_clk,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pull_up,
  output logic [NUM_PINS-1:0] pull_dn,
  output logic [NUM_PINS-1:0] status
);
  dio_cfg_t cfg_arr [NUM_PINS];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam dio_cfg_t PIN_RST = (i == CLK_PIN) ? CFG_CLKOUT : CFG_IDLE;
    dio_pin #(.RST_CFG(PIN_RST)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .pad_in  (pad_in[i]),
      .feat_clk(feat_clk),
      .load    (cfg_load[i]),
      .wdata   (cfg_wdata),
      .cfg_o   (cfg_arr[i]),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i]),
      .pull_up (pull_up[i]),
      .pull_dn (pull_dn[i]),
      .status  (status[i])
    );
  end

  always_comb begin
    rd_cfg = '0;
    for (int k = 0; k < NUM_PINS; k++)
      if (rd_pin == SEL_W'(k)) rd_cfg = cfg_arr[k];
  end

  // R3: output enable follows a loaded direction bit one clock later
  a_r3_dir_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load == NUM_PINS'(1)) |=> (pad_oe[0] == $past(cfg_wdata[0])));
endmodule

// File: tb/dio_quad_bench.sv
module dio_quad_bench;
  logic       clk = 1'b0, rst_n = 1'b0, feat_clk = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [3:0] cfg_load = '0, pad_in = '0;
  logic [1:0] rd_pin = '0;
  logic [5:0] rd_cfg;
  logic [3:0] pad_out, pad_oe, pull_up, pull_dn, status;

  int checks = 0, errors = 0;
  logic [5:0] cfg_m [4];
  logic       alm_m [4];
  bit         feat_run = 1'b1;

  dio_quad u_dio_quad (.clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata), .cfg_load(cfg_load),
    .rd_pin(rd_pin), .rd_cfg(rd_cfg), .feat_clk(feat_clk), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn), .status(status));

  always #5 clk = ~clk;

  initial begin
    int n = 0;
    while (feat_run) begin
      @(posedge clk); #1;
      n++;
      if (n % 3 == 0) feat_clk = ~feat_clk;
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_out(int p);
    if (!cfg_m[p][0]) return 1'b0;
    return cfg_m[p][3] ? feat_clk : cfg_m[p][1];
  endfunction

  function automatic logic exp_stat(int p);
    if (!cfg_m[p][0] && cfg_m[p][1]) return alm_m[p];
    return pad_in[p];
  endfunction

  task automatic check_all();
    for (int p = 0; p < 4; p++) begin
      chk("R3 pad_oe", 6'(pad_oe[p]), 6'(cfg_m[p][0]));
      chk("R4 pad_out", 6'(pad_out[p]), 6'(exp_out(p)));
      chk("R8 pull_up", 6'(pull_up[p]), 6'(cfg_m[p][4]));
      chk("R8 pull_dn", 6'(pull_dn[p]), 6'(cfg_m[p][5] & ~cfg_m[p][4]));
      chk("R9 R5 R6 status", 6'(status[p]), 6'(exp_stat(p)));
      rd_pin = 2'(p); #1;
      chk("R10 rd_cfg", rd_cfg, cfg_m[p]);
    end
  endtask

  task automatic load_pin(int p, logic [5:0] w);
    @(negedge clk);
    cfg_wdata = w; cfg_load = 4'b1 << p;
    @(negedge clk);
    cfg_load = '0;
    cfg_m[p] = w; alm_m[p] = 1'b0;
  endtask

  task automatic flip_pad(int p);
    logic nv;
    @(negedge clk);
    nv = ~pad_in[p];
    pad_in[p] = nv;
    if (!cfg_m[p][0] && cfg_m[p][1] && cfg_m[p][2] && (cfg_m[p][3] ? nv : !nv))
      alm_m[p] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < 4; p++) begin cfg_m[p] = 6'b0; alm_m[p] = 1'b0; end
    cfg_m[3] = 6'b001001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state, pin 3 follows feature clock over several samples
    check_all();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #2;
      chk("R1 R4 clkout", 6'(pad_out[3]), 6'(feat_clk));
    end
    // R2 data without a load is ignored
    @(negedge clk); cfg_wdata = 6'b111111;
    repeat (2) @(negedge clk);
    check_all();
    // R6 falling edge alarm, rising edge ignored; R7 hold
    load_pin(1, 6'b000110);
    flip_pad(1);  check_all();            // rising: no alarm
    chk("R6 no rise", 6'(status[1]), 6'd0);
    flip_pad(1);  check_all();            // falling: alarm
    chk("R6 fall latched", 6'(status[1]), 6'd1);
    flip_pad(1); flip_pad(1); check_all();
    chk("R7 alarm held", 6'(status[1]), 6'd1);
    load_pin(1, 6'b000110); repeat (2) @(negedge clk);
    chk("R7 load clears", 6'(status[1]), 6'd0);
    // R6 unarmed pin ignores edges
    load_pin(2, 6'b001010);
    flip_pad(2); flip_pad(2); check_all();
    chk("R6 unarmed", 6'(status[2]), 6'd0);
    // R8 both pulls requested
    load_pin(0, 6'b110000); repeat (2) @(negedge clk); check_all();
    // random mix
    for (int it = 0; it < 400; it++) begin
      int p = int'($urandom_range(3));
      if ($urandom_range(2) == 0) begin
        load_pin(p, 6'($urandom));
        repeat (3) @(negedge clk);
      end else flip_pad(p);
      #2 check_all();
    end
    feat_run = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule